// File: doc/BRIEF.md
# Double-Buffered DMA Channel Controller

One unidirectional channel of a peripheral-to-memory DMA engine. Software sets up a job through three word registers: a start address, a byte count and a control word. The channel keeps one running job and one waiting job. The next job can therefore be set up while the current one moves data, and the waiting job starts in the cycle after the running one ends.

For every beat the channel presents an element address and an element size to a memory port. When the port accepts the beat, the address steps by the element width and the remaining count drops by the same amount. A one-cycle completion pulse marks the last accepted beat of each job. A repeat mode restarts the finished job from its original address and count. A job that is waiting takes precedence over that restart. A clear command drops both jobs at once.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Register word offsets: 0 is the start address (low 16 bits kept, upper bits read 0), 1 is the byte count (low 17 bits kept, upper bits read 0), 2 is the control word, and offset 3 reads 0.
- R2: A read of the control word returns bit 0 repeat and bits 2:1 element size as last written, bit 4 busy (a job is running or waiting) and bit 5 pending (the waiting slot is occupied). All other bits are 0.
- R3: Writing the control word with bit 4 = 1 and bit 5 = 0 commits the staged address and count with the written size and repeat bits. The job goes to the running slot if that slot is free and otherwise to the waiting slot. A commit with a staged count of 0 is dropped.
- R4: `beat_valid_o` is 1 exactly while a job runs, carrying the current address and element size. A beat is accepted when `beat_ready_i` is 1. The address then advances modulo 2^16 by 1, 2 or 4 for element codes 00, 01 and 10, and by 4 for code 11.
- R5: Each accepted beat lowers the remaining count by the step. The beat accepted while the remaining count is at most the step is the last one. `done_o` is 1 in that same cycle only, unless a clear is written in that cycle.
- R6: When a job ends while the waiting slot is full, the waiting job presents its first beat in the next cycle, with no idle gap.
- R7: In repeat mode, a finished job restarts at its original address and count when no job waits. A waiting job replaces it instead.
- R8: A commit that arrives while both slots are full, and the running job is not finishing in that cycle, is ignored. Both jobs continue unchanged.
- R9: Writing the control word with bit 5 = 1 empties both slots. No beat is presented in the next cycle.
- R10: After reset no beat is presented, `done_o` is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_off_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the offset |
| beat_ready_i | input | 1 | Memory port accepts the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| beat_addr_o | output | 16 | Element address of the beat |
| beat_esize_o | output | 2 | Element size code of the beat |
| done_o | output | 1 | Last beat of a job accepted |

## Verification
The bench builds the channel with its default widths: a 16-bit address and a 17-bit count. At these widths an address wrap from 0xFFFE to 0x0000 and the masking of oversized writes take only a few cycles to reach. The small counts used, with one or two beats per job in repeat mode, let commits coincide with wraps and with last beats. This exercises the ordering of completion, enqueue and clear within one cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ES_B8  = 2'b00,
    ES_B16 = 2'b01,
    ES_B32 = 2'b10,
    ES_ALT = 2'b11
  } elem_e;

  typedef enum logic [1:0] {
    RO_ADDR = 2'd0,
    RO_SIZE = 2'd1,
    RO_CTRL = 2'd2,
    RO_NONE = 2'd3
  } reg_off_e;

  localparam int unsigned CB_REPEAT = 0;
  localparam int unsigned CB_ES_LO  = 1;
  localparam int unsigned CB_GO     = 4;
  localparam int unsigned CB_CLR    = 5;

  function automatic logic [2:0] elem_step(logic [1:0] es);
    case (es)
      ES_B8:   return 3'd1;
      ES_B16:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        off_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              pend_i,
  output logic [31:0]       rdata_o,
  output logic              enq_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] job_addr_o,
  output logic [SIZE_W-1:0] job_size_o,
  output logic [1:0]        job_es_o,
  output logic              job_rpt_o
);

  logic [ADDR_W-1:0] st_addr;
  logic [SIZE_W-1:0] st_size;
  logic [1:0]        st_es;
  logic              st_rpt;
  logic              wr_addr, wr_size, wr_ctrl;
  logic              unused_w;

  assign unused_w = ^wdata_i[31:SIZE_W];

  assign wr_addr = req_i && we_i && (off_i == RO_ADDR);
  assign wr_size = req_i && we_i && (off_i == RO_SIZE);
  assign wr_ctrl = req_i && we_i && (off_i == RO_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_addr <= '0;
      st_size <= '0;
      st_es   <= '0;
      st_rpt  <= 1'b0;
    end else begin
      if (wr_addr) st_addr <= wdata_i[ADDR_W-1:0];
      if (wr_size) st_size <= wdata_i[SIZE_W-1:0];
      if (wr_ctrl) begin
        st_rpt <= wdata_i[CB_REPEAT];
        st_es  <= wdata_i[CB_ES_LO+1:CB_ES_LO];
      end
    end
  end

  // commit uses the freshly written mode bits with the staged address/count
  assign clr_o      = wr_ctrl && wdata_i[CB_CLR];
  assign enq_o      = wr_ctrl && wdata_i[CB_GO] && !wdata_i[CB_CLR] && (st_size != '0);
  assign job_addr_o = st_addr;
  assign job_size_o = st_size;
  assign job_es_o   = wdata_i[CB_ES_LO+1:CB_ES_LO];
  assign job_rpt_o  = wdata_i[CB_REPEAT];

  always_comb begin
    rdata_o = '0;
    case (off_i)
      RO_ADDR: rdata_o[ADDR_W-1:0] = st_addr;
      RO_SIZE: rdata_o[SIZE_W-1:0] = st_size;
      RO_CTRL: begin
        rdata_o[CB_REPEAT]             = st_rpt;
        rdata_o[CB_ES_LO+1:CB_ES_LO]   = st_es;
        rdata_o[CB_GO]                 = busy_i;
        rdata_o[CB_CLR]                = pend_i;
      end
      default: rdata_o = '0;
    endcase
  end

  a_r1_size_keeps_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_size || wr_ctrl) |=> st_addr == $past(st_addr));

  a_r3_zero_count_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_size == '0) |-> !enq_o);

endmodule

// File: rtl/dma_beat_engine.sv
module dma_beat_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE_W = 17
) (
  input  logic              act_v_i,
  input  logic              ready_i,
  input  logic [1:0]        es_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [SIZE_W-1:0] rem_i,
  output logic              fire_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic [SIZE_W-1:0] nxt_rem_o
);

  logic [2:0] step;

  assign step       = elem_step(es_i);
  assign fire_o     = act_v_i && ready_i;
  assign last_o     = rem_i <= SIZE_W'(step);
  assign nxt_addr_o = cur_addr_i + ADDR_W'(step);
  assign nxt_rem_o  = rem_i - SIZE_W'(step);

endmodule

// File: rtl/dma_job_queue.sv
module dma_job_queue #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] job_addr_i,
  input  logic [SIZE_W-1:0] job_size_i,
  input  logic [1:0]        job_es_i,
  input  logic              job_rpt_i,
  input  logic              fire_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] nxt_addr_i,
  input  logic [SIZE_W-1:0] nxt_rem_i,
  output logic              act_v_o,
  output logic              sh_v_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [SIZE_W-1:0] rem_o,
  output logic [1:0]        es_o,
  output logic              done_o
);

  // running slot
  logic              act_v, n_act_v;
  logic [ADDR_W-1:0] act_a0, n_act_a0, cur_a, n_cur_a;
  logic [SIZE_W-1:0] act_s0, n_act_s0, rem, n_rem;
  logic [1:0]        act_es, n_act_es;
  logic              act_rpt, n_act_rpt;
  // waiting slot
  logic              sh_v, n_sh_v;
  logic [ADDR_W-1:0] sh_a, n_sh_a;
  logic [SIZE_W-1:0] sh_s, n_sh_s;
  logic [1:0]        sh_es, n_sh_es;
  logic              sh_rpt, n_sh_rpt;

  logic              finish;

  assign finish = fire_i && last_i;

  // order within a cycle: completion, then enqueue, then clear
  always_comb begin
    n_act_v = act_v;  n_act_a0 = act_a0; n_act_s0 = act_s0;
    n_cur_a = cur_a;  n_rem = rem;       n_act_es = act_es; n_act_rpt = act_rpt;
    n_sh_v  = sh_v;   n_sh_a = sh_a;     n_sh_s = sh_s;
    n_sh_es = sh_es;  n_sh_rpt = sh_rpt;

    if (fire_i) begin
      if (last_i) begin
        if (sh_v) begin
          n_act_a0  = sh_a;  n_cur_a = sh_a;
          n_act_s0  = sh_s;  n_rem   = sh_s;
          n_act_es  = sh_es; n_act_rpt = sh_rpt;
          n_sh_v    = 1'b0;
        end else if (act_rpt) begin
          n_cur_a = act_a0;
          n_rem   = act_s0;
        end else begin
          n_act_v = 1'b0;
        end
      end else begin
        n_cur_a = nxt_addr_i;
        n_rem   = nxt_rem_i;
      end
    end

    if (enq_i) begin
      if (!n_act_v) begin
        n_act_v   = 1'b1;
        n_act_a0  = job_addr_i; n_cur_a = job_addr_i;
        n_act_s0  = job_size_i; n_rem   = job_size_i;
        n_act_es  = job_es_i;   n_act_rpt = job_rpt_i;
      end else if (!n_sh_v) begin
        n_sh_v   = 1'b1;
        n_sh_a   = job_addr_i;
        n_sh_s   = job_size_i;
        n_sh_es  = job_es_i;
        n_sh_rpt = job_rpt_i;
      end
    end

    if (clr_i) begin
      n_act_v = 1'b0;
      n_sh_v  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_v <= 1'b0; act_a0 <= '0; act_s0 <= '0; cur_a <= '0; rem <= '0;
      act_es <= '0;  act_rpt <= 1'b0;
      sh_v <= 1'b0;  sh_a <= '0;   sh_s <= '0;   sh_es <= '0; sh_rpt <= 1'b0;
    end else begin
      act_v <= n_act_v; act_a0 <= n_act_a0; act_s0 <= n_act_s0;
      cur_a <= n_cur_a; rem <= n_rem; act_es <= n_act_es; act_rpt <= n_act_rpt;
      sh_v <= n_sh_v;   sh_a <= n_sh_a; sh_s <= n_sh_s;
      sh_es <= n_sh_es; sh_rpt <= n_sh_rpt;
    end
  end

  assign act_v_o    = act_v;
  assign sh_v_o     = sh_v;
  assign cur_addr_o = cur_a;
  assign rem_o      = rem;
  assign es_o       = act_es;
  assign done_o     = finish && !clr_i;

  a_r2_pend_implies_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_v |-> act_v);

  a_r3_idle_commit_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && !act_v && !clr_i) |=> act_v && cur_a == $past(job_addr_i));

  a_r5_running_count_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_v |-> rem != '0);

  a_r6_promote_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && sh_v && !clr_i) |=> act_v && cur_a == $past(sh_a) && rem == $past(sh_s));

  a_r7_repeat_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && act_rpt && !sh_v && !clr_i) |=> act_v && cur_a == $past(act_a0) && rem == $past(act_s0));

  a_r8_full_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && act_v && sh_v && !finish && !clr_i) |=> sh_a == $past(sh_a) && sh_s == $past(sh_s) && sh_v);

  a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !act_v && !sh_v);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_off_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              beat_ready_i,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [1:0]        beat_esize_o,
  output logic              done_o
);

  logic              enq, clr, act_v, sh_v, fire, last;
  logic [ADDR_W-1:0] job_addr, cur_addr, nxt_addr;
  logic [SIZE_W-1:0] job_size, rem, nxt_rem;
  logic [1:0]        job_es, act_es;
  logic              job_rpt;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .off_i      (reg_off_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (act_v),
    .pend_i     (sh_v),
    .rdata_o    (reg_rdata_o),
    .enq_o      (enq),
    .clr_o      (clr),
    .job_addr_o (job_addr),
    .job_size_o (job_size),
    .job_es_o   (job_es),
    .job_rpt_o  (job_rpt)
  );

  dma_job_queue #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enq_i      (enq),
    .clr_i      (clr),
    .job_addr_i (job_addr),
    .job_size_i (job_size),
    .job_es_i   (job_es),
    .job_rpt_i  (job_rpt),
    .fire_i     (fire),
    .last_i     (last),
    .nxt_addr_i (nxt_addr),
    .nxt_rem_i  (nxt_rem),
    .act_v_o    (act_v),
    .sh_v_o     (sh_v),
    .cur_addr_o (cur_addr),
    .rem_o      (rem),
    .es_o       (act_es),
    .done_o     (done_o)
  );

  dma_beat_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_engine (
    .act_v_i    (act_v),
    .ready_i    (beat_ready_i),
    .es_i       (act_es),
    .cur_addr_i (cur_addr),
    .rem_i      (rem),
    .fire_o     (fire),
    .last_o     (last),
    .nxt_addr_o (nxt_addr),
    .nxt_rem_o  (nxt_rem)
  );

  assign beat_valid_o = act_v;
  assign beat_addr_o  = cur_addr;
  assign beat_esize_o = act_es;

  a_r4_addr_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last && !clr) |=> beat_valid_o && beat_addr_o == $past(beat_addr_o) + ADDR_W'(elem_step($past(act_es))));

  a_r4_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i && !clr) |=> beat_valid_o && $stable(beat_addr_o));

  a_r5_done_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> beat_valid_o && beat_ready_i);

endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_off = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ready = 1'b0;
  logic        beat_valid, done;
  logic [15:0] beat_addr;
  logic [1:0]  beat_esize;

  int total = 0, bad = 0, cyc_n = 0, wd = 0;
  int log_n = 0, n_done = 0;
  int addr_log [64];
  int cyc_log  [64];

  // reference model state
  int m_av = 0, m_a0 = 0, m_s0 = 0, m_cur = 0, m_rem = 0, m_es = 0, m_ct = 0;
  int m_sv = 0, s_a = 0, s_s = 0, s_es = 0, s_ct = 0;
  int st_a = 0, st_s = 0, st_es = 0, st_ct = 0;

  always #5 clk = ~clk;

  dma_chan_ctrl u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .reg_req_i (reg_req), .reg_we_i (reg_we), .reg_off_i (reg_off),
    .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
    .beat_ready_i (ready), .beat_valid_o (beat_valid),
    .beat_addr_o (beat_addr), .beat_esize_o (beat_esize), .done_o (done)
  );

  function automatic int stepof(int es);
    return (es == 0) ? 1 : (es == 1) ? 2 : 4;
  endfunction

  function automatic int mread(int off);
    case (off)
      0: return st_a;
      1: return st_s;
      2: return st_ct | (st_es << 1) | (m_av << 4) | (m_sv << 5);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    int stp, w, ja, js, jes, jct;
    bit fire, last, clr, wr, enq;
    #1;
    stp  = stepof(m_es);
    fire = (m_av != 0) && ready;
    last = m_rem <= stp;
    w    = reg_wdata;
    wr   = reg_req && reg_we;
    clr  = wr && reg_off == 2 && w[5];
    check("R4 valid", int'(beat_valid), m_av);
    if (m_av != 0) begin
      check("R4 addr", int'(beat_addr), m_cur);
      check("R4 esize", int'(beat_esize), m_es);
    end
    check("R5 done", int'(done), int'(fire && last && !clr));
    if (reg_req && !reg_we) check("R2 read", int'(reg_rdata), mread(int'(reg_off)));
    if (beat_valid && ready && log_n < 64) begin
      addr_log[log_n] = int'(beat_addr);
      cyc_log[log_n]  = cyc_n;
      log_n++;
    end
    if (done) n_done++;
    @(posedge clk);
    cyc_n++;
    enq = wr && reg_off == 2 && w[4] && !w[5] && st_s != 0;
    ja = st_a; js = st_s; jes = (w >> 1) & 3; jct = w & 1;
    if (wr) begin
      case (reg_off)
        2'd0: st_a = w & 32'hffff;
        2'd1: st_s = w & 32'h1ffff;
        2'd2: begin st_ct = w & 1; st_es = (w >> 1) & 3; end
        default: ;
      endcase
    end
    if (fire) begin
      if (last) begin
        if (m_sv != 0) begin
          m_a0 = s_a; m_cur = s_a; m_s0 = s_s; m_rem = s_s; m_es = s_es; m_ct = s_ct; m_sv = 0;
        end else if (m_ct != 0) begin
          m_cur = m_a0; m_rem = m_s0;
        end else m_av = 0;
      end else begin
        m_cur = (m_cur + stp) & 32'hffff;
        m_rem = m_rem - stp;
      end
    end
    if (enq) begin
      if (m_av == 0) begin
        m_av = 1; m_a0 = ja; m_cur = ja; m_s0 = js; m_rem = js; m_es = jes; m_ct = jct;
      end else if (m_sv == 0) begin
        m_sv = 1; s_a = ja; s_s = js; s_es = jes; s_ct = jct;
      end
    end
    if (clr) begin m_av = 0; m_sv = 0; end
    @(negedge clk);
    reg_req = 1'b0;
    reg_we  = 1'b0;
  endtask

  task automatic wr(int off, int data);
    reg_req = 1'b1; reg_we = 1'b1; reg_off = 2'(off); reg_wdata = data;
    cyc();
  endtask

  task automatic rd(int off);
    reg_req = 1'b1; reg_we = 1'b0; reg_off = 2'(off);
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic job(int a, int s, int c);
    wr(0, a); wr(1, s); wr(2, c);
  endtask

  task automatic clear_log();
    log_n = 0; n_done = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++; total++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", wd, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 valid", int'(beat_valid), 0);
    check("R10 done", int'(done), 0);
    rd(2); check("R10 ctrl", int'(reg_rdata), 0);

    // R1 masking and unused offset
    wr(0, 32'h0001_2345); wr(1, 32'hffff_ffff);
    reg_req = 1; reg_we = 0; reg_off = 2'd0; #1; check("R1 addr", int'(reg_rdata), 32'h2345); cyc();
    reg_req = 1; reg_we = 0; reg_off = 2'd1; #1; check("R1 size", int'(reg_rdata), 32'h1ffff); cyc();
    reg_req = 1; reg_we = 0; reg_off = 2'd3; #1; check("R1 off3", int'(reg_rdata), 0); cyc();

    // R3 zero count dropped
    ready = 1'b1;
    job(32'h40, 0, 32'h10);
    reg_req = 1; reg_we = 0; reg_off = 2'd2; #1; check("R3 zero busy", int'(reg_rdata), 32'h0); cyc();

    // R3 basic byte job
    clear_log();
    job(32'h100, 4, 32'h10);
    idle(6);
    check("R3 beats", log_n, 4);
    check("R4 last byte addr", addr_log[3], 32'h103);
    check("R5 one done", n_done, 1);

    // R6 / R8 back-to-back with an ignored third commit
    clear_log();
    job(32'h200, 16, 32'h12);
    job(32'h300, 8, 32'h14);
    reg_req = 1; reg_we = 0; reg_off = 2'd2; #1; check("R2 pending", int'(reg_rdata), 32'h34); cyc();
    job(32'h400, 4, 32'h10);
    idle(8);
    check("R8 beat count", log_n, 10);
    check("R6 promoted addr", addr_log[8], 32'h300);
    check("R6 no gap", cyc_log[8] - cyc_log[7], 1);
    check("R4 word step", addr_log[9], 32'h304);
    check("R5 two done", n_done, 2);
    rd(2);

    // R7 repeat, then a waiting job takes over
    wr(0, 32'h500); wr(1, 8);
    clear_log();
    wr(2, 32'h15);
    idle(6);
    job(32'h600, 2, 32'h10);
    idle(6);
    check("R7 beats", log_n, 12);
    check("R7 wrap addr", addr_log[2], 32'h500);
    check("R7 takeover", addr_log[10], 32'h600);
    check("R7 final", addr_log[11], 32'h601);
    check("R7 done count", n_done, 6);

    // R9 clear
    job(32'h700, 100, 32'h10);
    job(32'h780, 4, 32'h10);
    wr(2, 32'h20);
    check("R9 no beat", int'(beat_valid), 0);
    clear_log();
    reg_req = 1; reg_we = 0; reg_off = 2'd2; #1; check("R9 ctrl", int'(reg_rdata), 0); cyc();
    idle(5);
    check("R9 silent", log_n, 0);

    // R5 odd count, R4 code 11 and address wrap
    clear_log();
    job(32'h900, 3, 32'h14);
    idle(3);
    check("R5 odd count beats", log_n, 1);
    check("R5 odd count done", n_done, 1);
    clear_log();
    job(32'h800, 8, 32'h16);
    idle(4);
    check("R4 code11 step", addr_log[1], 32'h804);
    clear_log();
    job(32'hfffe, 4, 32'h12);
    idle(4);
    check("R4 addr wrap", addr_log[1], 0);

    // R4 / R5 under a stalling memory port
    clear_log();
    ready = 1'b0;
    job(32'ha00, 6, 32'h12);
    for (int i = 0; i < 12; i++) begin
      ready = i[0];
      cyc();
    end
    ready = 1'b1;
    idle(2);
    check("R4 stalled beats", log_n, 3);
    check("R4 stalled addr", addr_log[2], 32'ha04);
    check("R5 stalled done", n_done, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule